// File: doc/BRIEF.md
# Instruction TLB Replacement Age Tracker

This block keeps the recency state for a four-way instruction translation buffer. The state is six pairwise-age bits held in the top of a 32-bit control word (bits 31:26). Each bit records which of two ways was touched more recently. Every time a way is used, the lookup logic pulses an access strobe with that way's index. The block then sets and clears a fixed group of age bits for that way and leaves every other bit of the word alone.

A refill asks which way to overwrite. The block answers with no clock delay by comparing the age field against one fixed pattern per way. Some age patterns match no way, for example after software has loaded an arbitrary value. For those the block raises an error flag and nominates way 0. Software can replace the whole control word at any time through a write port, and that write takes priority over an access in the same cycle.

Top module: `itlb_lru_tracker`

## Requirements
- R1: After reset the control word equals the RESET_VAL parameter (default all zeros), so the victim is way 3 and the error flag is low.
- R2: The victim is combinational on the current word. Way 0 is chosen when bits 31, 30 and 29 are all 1. Way 1 is chosen when bit 31 = 0, bit 28 = 0 and bit 27 = 1. Way 2 is chosen when bit 30 = 0, bit 28 = 1 and bit 26 = 1. Way 3 is chosen when bits 29, 27 and 26 are all 0.
- R3: When the age field matches none of the four patterns in R2, pattern_err is 1 and victim_way is 0. Otherwise pattern_err is 0.
- R4: An access to way 0 clears bits 31, 30 and 29 at the next clock edge and leaves bits 28:26 unchanged.
- R5: An access to way 1 sets bit 31 and clears bits 28 and 27 at the next clock edge. Bits 30, 29 and 26 are unchanged.
- R6: An access to way 2 sets bits 30 and 28 and clears bit 26 at the next clock edge. Bits 31, 29 and 27 are unchanged.
- R7: An access to way 3 sets bits 29, 27 and 26 at the next clock edge. Bits 31, 30 and 28 are unchanged.
- R8: An access never changes bits 25:0 of the control word.
- R9: A software write replaces the whole control word at the next clock edge. If an access is strobed in the same cycle, the access is ignored.
- R10: In a cycle with neither an access nor a software write, the control word holds its value. This holds even while acc_way changes.
- R11: After an access to way k, the next victim is never k unless pattern_err is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe: a way was just used |
| acc_way | input | 2 | Index of the way just used |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | New control word for a software write |
| ctl_word | output | 32 | Current control word; age field in bits 31:26 |
| victim_way | output | 2 | Way to replace on a refill |
| pattern_err | output | 1 | The age field matches no victim pattern |

## Verification
The assertions check the following on every cycle:
- Each access-driven edit to the age field (R4 to R7).
- That an access leaves the low 26 bits alone (R8).
- That a software write lands in full (R9).
- That the word is held when idle (R10).
- That a way just used is never nominated next unless the error flag is up (R11).

Some behaviours can only be shown by the bench's scenarios:
- The exact victim decoded from each age pattern (R2).
- Which patterns match no way (R3).
- The reset contents (R1).

The bench walks a table of loaded patterns and accesses to cover these, including patterns reached only by software loads.

// File: rtl/itlb_lru_pkg.sv
package itlb_lru_pkg;
   localparam int LRU_W = 6;
   localparam int WAYS  = 4;
   localparam int IDX_W = $clog2(WAYS);

   // Field bit f[5..0] corresponds to control word bits 31..26.
   function automatic logic [LRU_W-1:0] match_mask(input logic [IDX_W-1:0] w);
      case (w)
         2'd0:    return 6'b111000;
         2'd1:    return 6'b100110;
         2'd2:    return 6'b010101;
         default: return 6'b001011;
      endcase
   endfunction

   function automatic logic [LRU_W-1:0] match_value(input logic [IDX_W-1:0] w);
      case (w)
         2'd0:    return 6'b111000;
         2'd1:    return 6'b000010;
         2'd2:    return 6'b000101;
         default: return 6'b000000;
      endcase
   endfunction

   function automatic logic [LRU_W-1:0] touch_set(input logic [IDX_W-1:0] w);
      case (w)
         2'd0:    return 6'b000000;
         2'd1:    return 6'b100000;
         2'd2:    return 6'b010100;
         default: return 6'b001011;
      endcase
   endfunction

   function automatic logic [LRU_W-1:0] touch_clear(input logic [IDX_W-1:0] w);
      case (w)
         2'd0:    return 6'b111000;
         2'd1:    return 6'b000110;
         2'd2:    return 6'b000001;
         default: return 6'b000000;
      endcase
   endfunction
endpackage

// File: rtl/itlb_lru_next.sv
module itlb_lru_next
   import itlb_lru_pkg::*;
(
   input  logic [LRU_W-1:0] age_i,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] way_i,
   output logic [LRU_W-1:0] age_o
);
   logic [LRU_W-1:0] set_tab [WAYS];
   logic [LRU_W-1:0] clr_tab [WAYS];
   logic [LRU_W-1:0] set_m, clr_m;

   for (genvar g = 0; g < WAYS; g++) begin : g_tab
      assign set_tab[g] = touch_set(IDX_W'(g));
      assign clr_tab[g] = touch_clear(IDX_W'(g));
   end

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (touch_i) begin
         set_m = set_tab[way_i];
         clr_m = clr_tab[way_i];
      end
      age_o = (age_i & ~clr_m) | set_m;
   end
endmodule

// File: rtl/itlb_lru_victim.sv
module itlb_lru_victim
   import itlb_lru_pkg::*;
#(
   parameter bit ONEHOT_ENCODE = 1'b1
)(
   input  logic [LRU_W-1:0] age_i,
   output logic [IDX_W-1:0] victim_o,
   output logic             none_o
);
   logic [WAYS-1:0] hit;

   for (genvar g = 0; g < WAYS; g++) begin : g_hit
      assign hit[g] = ((age_i & match_mask(IDX_W'(g))) == match_value(IDX_W'(g)));
   end

   if (ONEHOT_ENCODE) begin : g_or_enc
      // The match patterns are mutually exclusive, so an OR of indices suffices.
      always_comb begin
         victim_o = '0;
         for (int w = 0; w < WAYS; w++)
            if (hit[w]) victim_o = victim_o | IDX_W'(w);
      end
   end else begin : g_prio_enc
      always_comb begin
         victim_o = '0;
         for (int w = WAYS - 1; w >= 0; w--)
            if (hit[w]) victim_o = IDX_W'(w);
      end
   end

   assign none_o = ~|hit;
endmodule

// File: rtl/itlb_lru_tracker.sv
module itlb_lru_tracker
   import itlb_lru_pkg::*;
#(
   parameter int              REG_W         = 32,
   parameter int              FIELD_LSB     = 26,
   parameter logic [REG_W-1:0] RESET_VAL    = '0,
   parameter bit              ONEHOT_ENCODE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [1:0]       acc_way,
   input  logic             sw_wr_en,
   input  logic [31:0]      sw_wr_data,
   output logic [31:0]      ctl_word,
   output logic [1:0]       victim_way,
   output logic             pattern_err
);
   localparam int FIELD_MSB = FIELD_LSB + LRU_W - 1;

   if (FIELD_MSB >= REG_W) begin : g_bad_field
      $error("age field does not fit in the control word");
   end
   if (REG_W != 32) begin : g_bad_width
      $error("control word must be 32 bits wide");
   end
   if (WAYS != 4) begin : g_bad_ways
      $error("tracker supports exactly four ways");
   end

   logic [REG_W-1:0] ctl_q, ctl_d;
   logic [LRU_W-1:0] age_q, age_nxt;

   assign age_q = ctl_q[FIELD_MSB:FIELD_LSB];

   itlb_lru_next u_next (
      .age_i   (age_q),
      .touch_i (acc_valid),
      .way_i   (acc_way),
      .age_o   (age_nxt)
   );

   itlb_lru_victim #(.ONEHOT_ENCODE(ONEHOT_ENCODE)) u_victim (
      .age_i    (age_q),
      .victim_o (victim_way),
      .none_o   (pattern_err)
   );

   always_comb begin
      ctl_d = ctl_q;
      if (sw_wr_en) ctl_d = sw_wr_data;
      else          ctl_d[FIELD_MSB:FIELD_LSB] = age_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= RESET_VAL;
      else        ctl_q <= ctl_d;
   end

   assign ctl_word = ctl_q;

   // R4
   touch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sw_wr_en && acc_way == 2'd0) |=>
      (ctl_word[31:29] == 3'b000 && ctl_word[28:26] == $past(ctl_word[28:26])));
   // R5
   touch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sw_wr_en && acc_way == 2'd1) |=>
      (ctl_word[31] && ctl_word[28:27] == 2'b00 &&
       ctl_word[30:29] == $past(ctl_word[30:29]) && ctl_word[26] == $past(ctl_word[26])));
   // R6
   touch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sw_wr_en && acc_way == 2'd2) |=>
      (ctl_word[30] && ctl_word[28] && !ctl_word[26] &&
       ctl_word[31] == $past(ctl_word[31]) && ctl_word[29] == $past(ctl_word[29]) &&
       ctl_word[27] == $past(ctl_word[27])));
   // R7
   touch3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sw_wr_en && acc_way == 2'd3) |=>
      (ctl_word[29] && ctl_word[27] && ctl_word[26] &&
       ctl_word[31:30] == $past(ctl_word[31:30]) && ctl_word[28] == $past(ctl_word[28])));
   // R8
   low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr_en |=> (ctl_word[25:0] == $past(ctl_word[25:0])));
   // R9
   sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en |=> (ctl_word == $past(sw_wr_data)));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr_en && !acc_valid) |=> $stable(ctl_word));
   // R11
   fresh_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sw_wr_en) |=> (pattern_err || victim_way != $past(acc_way)));
endmodule

// File: tb/itlb_lru_tracker_test.sv
`timescale 1ns/1ps
module itlb_lru_tracker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_way = 2'd0;
   logic        sw_wr_en = 1'b0;
   logic [31:0] sw_wr_data = '0;
   logic [31:0] ctl_word;
   logic [1:0]  victim_way;
   logic        pattern_err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   itlb_lru_tracker uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_way(acc_way),
      .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
      .ctl_word(ctl_word), .victim_way(victim_way), .pattern_err(pattern_err)
   );

   // start[19:14] way[13:12] vb[11:10] eb[9] end[8:3] va[2:1] ea[0]
   localparam logic [19:0] VEC [12] = '{
      {6'b000000, 2'd0, 2'd3, 1'b0, 6'b000000, 2'd3, 1'b0},
      {6'b000000, 2'd1, 2'd3, 1'b0, 6'b100000, 2'd3, 1'b0},
      {6'b100000, 2'd2, 2'd3, 1'b0, 6'b110100, 2'd3, 1'b0},
      {6'b110100, 2'd3, 2'd3, 1'b0, 6'b111111, 2'd0, 1'b0},
      {6'b111111, 2'd0, 2'd0, 1'b0, 6'b000111, 2'd2, 1'b0},
      {6'b000111, 2'd2, 2'd2, 1'b0, 6'b010110, 2'd0, 1'b1},
      {6'b010110, 2'd1, 2'd0, 1'b1, 6'b110000, 2'd3, 1'b0},
      {6'b110000, 2'd0, 2'd3, 1'b0, 6'b000000, 2'd3, 1'b0},
      {6'b000010, 2'd3, 2'd1, 1'b0, 6'b001011, 2'd1, 1'b0},
      {6'b100001, 2'd1, 2'd0, 1'b1, 6'b100001, 2'd0, 1'b1},
      {6'b000101, 2'd0, 2'd2, 1'b0, 6'b000101, 2'd2, 1'b0},
      {6'b011000, 2'd3, 2'd0, 1'b1, 6'b011011, 2'd1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input bit wr, input logic [31:0] data, input bit av, input logic [1:0] way);
      @(negedge clk);
      sw_wr_en = wr; sw_wr_data = data; acc_valid = av; acc_way = way;
      @(posedge clk);
      @(negedge clk);
      sw_wr_en = 1'b0; acc_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset contents
      chk("R1 word", ctl_word, 32'h0);
      chk("R1 victim", {30'd0, victim_way}, 32'd3);
      chk("R1 err", {31'd0, pattern_err}, 32'd0);

      for (int i = 0; i < 12; i++) begin
         logic [19:0] v;
         logic [25:0] low;
         string utag;
         v = VEC[i];
         low = 26'h2A5_A5C ^ 26'(i * 37);
         step(1'b1, {v[19:14], low}, 1'b0, 2'd0);
         chk("R9 load", ctl_word, {v[19:14], low});
         chk("R2 victim before", {30'd0, victim_way}, {30'd0, v[11:10]});
         chk("R3 err before", {31'd0, pattern_err}, {31'd0, v[9]});
         step(1'b0, '0, 1'b1, v[13:12]);
         case (v[13:12])
            2'd0: utag = "R4 field";
            2'd1: utag = "R5 field";
            2'd2: utag = "R6 field";
            default: utag = "R7 field";
         endcase
         chk(utag, {26'd0, ctl_word[31:26]}, {26'd0, v[8:3]});
         chk("R8 low bits", {6'd0, ctl_word[25:0]}, {6'd0, low});
         chk("R2 R11 victim after", {30'd0, victim_way}, {30'd0, v[2:1]});
         chk("R3 err after", {31'd0, pattern_err}, {31'd0, v[0]});
      end

      // R10 idle cycles hold the word while acc_way toggles
      step(1'b1, 32'h5400_0ABC, 1'b0, 2'd0);
      step(1'b0, '0, 1'b0, 2'd1);
      step(1'b0, '0, 1'b0, 2'd3);
      chk("R10 hold", ctl_word, 32'h5400_0ABC);

      // R9 software write beats a simultaneous access
      step(1'b1, 32'hFC00_1234, 1'b1, 2'd0);
      chk("R9 priority", ctl_word, 32'hFC00_1234);
      chk("R2 victim 0", {30'd0, victim_way}, 32'd0);

      // R11 back-to-back touches 0,1,2,3 from zero leave way 0 oldest
      step(1'b1, 32'h0000_0000, 1'b0, 2'd0);
      for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 2'(k));
      chk("R11 sequence field", {26'd0, ctl_word[31:26]}, 32'h3F);
      chk("R11 sequence victim", {30'd0, victim_way}, 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule